// File: doc/BRIEF.md
# Integer Compare, Carry and Byte-Match Unit

This block is a helper datapath for a small processor's arithmetic unit. It accepts two operands `a` and `b`, a carry-in and a two-bit operation code. It produces a result word and a carry-out. It supports four operations:

- a signed compare;
- an unsigned compare;
- a carry-out prediction for `a + b + cin`;
- a byte-lane match that finds the first equal byte.

The compare operations return the difference `b - a`. When the operand signs disagree, the top bit of that difference is overwritten so that it gives the ordering of the operands. Software tests the sign of the compare result to branch.

The operation logic is combinational. An output register stage, chosen by a parameter and enabled by default, captures the result and the carry at each rising clock edge. A synchronous active-high reset clears that register.

Top module: `intcmp_unit`

## Requirements
- R1: With the output stage enabled, `res_o` and `cout_o` show the outcome of the inputs present at a rising `clk` edge, starting just after that edge. A rising edge with `rst` high clears both outputs to zero, whatever the inputs are.
- R2: Operation code 2'b00 (signed compare): when bit 31 of `a` differs from bit 31 of `b`, `res_o` bits 30:0 equal (b − a) mod 2^32, and bit 31 takes the value of bit 31 of `b`.
- R3: Operation code 2'b01 (unsigned compare): when bit 31 of `a` differs from bit 31 of `b`, `res_o` bits 30:0 equal (b − a) mod 2^32, and bit 31 takes the value of bit 31 of `a`.
- R4: For both compare codes, when bit 31 of `a` equals bit 31 of `b`, `res_o` equals (b − a) mod 2^32 in full.
- R5: Operation code 2'b10 (carry): `cout_o` is 1 when `b` is all ones and `cin_i` is 1. Otherwise `cout_o` is 1 exactly when (~a) < ((b + cin) mod 2^32), compared unsigned. For this code `res_o` is zero.
- R6: For operation codes other than 2'b10, `cout_o` is 0.
- R7: Operation code 2'b11 (byte match): lanes are numbered from the most significant byte: lane 1 is bits 31:24, lane 2 is bits 23:16, lane 3 is bits 15:8 and lane 4 is bits 7:0. `res_o` is the number of the lowest-numbered lane in which `a` and `b` hold the same byte, zero-extended to 32 bits.
- R8: In byte match, when several lanes match, the lowest-numbered lane wins, whatever the later lanes hold.
- R9: In byte match, `res_o` is 0 when no lane of `a` equals the same lane of `b`.
- R10: `cin_i` has no effect on `res_o` for the compare and byte-match codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| op_i | input | 2 | Operation code: 00 signed compare, 01 unsigned compare, 10 carry, 11 byte match |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| cin_i | input | 1 | Carry-in |
| res_o | output | 32 | Compare difference, or byte-match lane number, or zero for the carry code |
| cout_o | output | 1 | Carry-out; zero unless the carry code is selected |

## Verification
With the default output stage, every result and carry is due one cycle after the inputs are applied. The bench changes the inputs on a falling edge, lets one rising edge capture them, and reads the outputs on the next falling edge. Reset is checked the same way: `rst` and non-zero inputs are applied together, and the outputs must read zero half a cycle after the capturing edge. The bound checker relates each output to the inputs of the previous cycle through `$past`, which matches the same one-cycle delay.

// File: rtl/intcmp_pkg.sv
package intcmp_pkg;

    localparam int DEF_WIDTH  = 32;
    localparam int DEF_LANE_W = 8;

    typedef enum logic [1:0] {
        OP_SCMP   = 2'b00,
        OP_UCMP   = 2'b01,
        OP_CARRY  = 2'b10,
        OP_BMATCH = 2'b11
    } icmp_op_e;

    // Top bit of a compare result: the raw difference bit when the signs
    // agree, otherwise the sign of the operand picked for the ordering.
    function automatic logic order_msb(input logic raw_msb,
                                       input logic a_msb,
                                       input logic b_msb,
                                       input logic signed_cmp);
        logic pick;
        pick = signed_cmp ? b_msb : a_msb;
        return (a_msb ^ b_msb) ? pick : raw_msb;
    endfunction

endpackage

// File: rtl/intcmp_compare.sv
module intcmp_compare
    import intcmp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] diff_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] raw;

    assign raw = b_i + ~a_i + WIDTH'(1);

    always_comb begin
        diff_o      = raw;
        diff_o[MSB] = order_msb(raw[MSB], a_i[MSB], b_i[MSB], signed_i);
    end
endmodule

// File: rtl/intcmp_carry.sv
module intcmp_carry
    import intcmp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic             cout_o
);
    logic [WIDTH-1:0] headroom;
    logic [WIDTH-1:0] addend;
    logic             b_full;

    assign headroom = ~a_i;
    assign addend   = b_i + WIDTH'(cin_i);
    assign b_full   = &b_i;
    assign cout_o   = (b_full & cin_i) | (headroom < addend);
endmodule

// File: rtl/intcmp_bytematch.sv
module intcmp_bytematch
    import intcmp_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int LANE_W = DEF_LANE_W,
    parameter int IDX_W  = $clog2(WIDTH / LANE_W + 1)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam int LANES = WIDTH / LANE_W;

    // hit[k] belongs to lane k+1, counted from the most significant byte.
    logic [LANES-1:0] hit;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int TOP = WIDTH - 1 - k * LANE_W;
        assign hit[k] = (a_i[TOP -: LANE_W] == b_i[TOP -: LANE_W]);
    end

    // Scan from the least significant lane upward so that the most
    // significant matching lane is written last and wins.
    always_comb begin
        idx_o = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (hit[k]) idx_o = IDX_W'(k + 1);
        end
    end
endmodule

// File: rtl/intcmp_unit.sv
module intcmp_unit
    import intcmp_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int LANE_W  = DEF_LANE_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int LANES = WIDTH / LANE_W;
    localparam int IDX_W = $clog2(LANES + 1);

    icmp_op_e         op;
    logic [WIDTH-1:0] cmp_res;
    logic             cy;
    logic [IDX_W-1:0] bm_idx;
    logic [WIDTH-1:0] nxt_res;
    logic             nxt_cout;

    assign op = icmp_op_e'(op_i);

    intcmp_compare #(.WIDTH(WIDTH)) u_cmp (
        .a_i      (a_i),
        .b_i      (b_i),
        .signed_i (op == OP_SCMP),
        .diff_o   (cmp_res)
    );

    intcmp_carry #(.WIDTH(WIDTH)) u_cy (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .cout_o (cy)
    );

    intcmp_bytematch #(.WIDTH(WIDTH), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_bm (
        .a_i   (a_i),
        .b_i   (b_i),
        .idx_o (bm_idx)
    );

    always_comb begin
        nxt_res  = '0;
        nxt_cout = 1'b0;
        unique case (op)
            OP_SCMP, OP_UCMP: nxt_res  = cmp_res;
            OP_CARRY:         nxt_cout = cy;
            OP_BMATCH:        nxt_res  = WIDTH'(bm_idx);
            default:          nxt_res  = '0;
        endcase
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                res_o  <= nxt_res;
                cout_o <= nxt_cout;
            end
        end
    end else begin : g_comb
        assign res_o  = nxt_res;
        assign cout_o = nxt_cout;
    end
endmodule

// File: rtl/intcmp_unit_chk.sv
module intcmp_unit_chk #(
    parameter int WIDTH   = 32,
    parameter int LANE_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    localparam int MSB   = WIDTH - 1;
    localparam int LANES = WIDTH / LANE_W;

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    if (OUT_REG) begin : g_props
        assert_reset_clears_R1: assert property (@(posedge clk)
            armed && $past(rst) |-> (res_o == '0) && !cout_o);

        assert_signed_msb_R2: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b00) && ($past(a_i[MSB]) != $past(b_i[MSB]))
            |-> res_o[MSB] == $past(b_i[MSB]));

        assert_unsigned_msb_R3: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b01) && ($past(a_i[MSB]) != $past(b_i[MSB]))
            |-> res_o[MSB] == $past(a_i[MSB]));

        assert_same_sign_diff_R4: assert property (@(posedge clk) disable iff (rst || !armed)
            !$past(op_i[1]) && ($past(a_i[MSB]) == $past(b_i[MSB]))
            |-> res_o == $past(b_i - a_i));

        assert_carry_res_zero_R5: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b10) |-> res_o == '0);

        assert_no_cout_R6: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) != 2'b10) |-> !cout_o);

        assert_match_range_R7: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b11) |-> res_o <= WIDTH'(LANES));

        assert_first_lane_R8: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b11) && ($past(a_i[MSB -: LANE_W]) == $past(b_i[MSB -: LANE_W]))
            |-> res_o == WIDTH'(1));

        assert_no_match_R9: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(op_i) == 2'b11) && (res_o == '0)
            |-> $past(a_i[LANE_W-1:0]) != $past(b_i[LANE_W-1:0]));
    end
endmodule

bind intcmp_unit intcmp_unit_chk #(
    .WIDTH   (WIDTH),
    .LANE_W  (LANE_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/intcmp_unit_test.sv
`timescale 1ns/1ps
module intcmp_unit_test;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [31:0] res;
        logic        cout;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0000_0005, 32'h0000_0003, 1'b0, 32'hFFFF_FFFE, 1'b0},
        '{2'd0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b0},
        '{2'd1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b0},
        '{2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h0000_0001, 1'b0},
        '{2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h8000_0001, 1'b0},
        '{2'd0, 32'h0000_0003, 32'h0000_0003, 1'b1, 32'h0000_0000, 1'b0},
        '{2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b1},
        '{2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0},
        '{2'd2, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1},
        '{2'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{2'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0},
        '{2'd3, 32'h1234_5678, 32'h1200_0000, 1'b0, 32'h0000_0001, 1'b0},
        '{2'd3, 32'h1234_5678, 32'h0034_5678, 1'b0, 32'h0000_0002, 1'b0},
        '{2'd3, 32'h1234_5678, 32'h0000_5678, 1'b0, 32'h0000_0003, 1'b0},
        '{2'd3, 32'h1234_5678, 32'h0000_0078, 1'b0, 32'h0000_0004, 1'b0},
        '{2'd3, 32'h1234_5678, 32'hEDCB_A987, 1'b0, 32'h0000_0000, 1'b0},
        '{2'd3, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0},
        '{2'd1, 32'h0000_0000, 32'h7FFF_FFFF, 1'b1, 32'h7FFF_FFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_i = 2'd0;
    logic [31:0] a_i = 32'h0;
    logic [31:0] b_i = 32'h0;
    logic        cin_i = 1'b0;
    logic [31:0] res_o;
    logic        cout_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    intcmp_unit uut (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .res_o  (res_o),
        .cout_o (cout_o)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic cin,
                                  output logic [31:0] r, output logic c);
        logic [31:0] d;
        r = 32'h0;
        c = 1'b0;
        d = b - a;
        case (op)
            2'd0: r = (a[31] != b[31]) ? {b[31], d[30:0]} : d;   // R2, R4
            2'd1: r = (a[31] != b[31]) ? {a[31], d[30:0]} : d;   // R3, R4
            2'd2: c = ((b == 32'hFFFF_FFFF) && cin) || (~a < (b + {31'd0, cin})); // R5
            default: begin                                       // R7, R8, R9
                if (a[7:0] == b[7:0])     r = 32'd4;
                if (a[15:8] == b[15:8])   r = 32'd3;
                if (a[23:16] == b[23:16]) r = 32'd2;
                if (a[31:24] == b[31:24]) r = 32'd1;
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic ec);
        checks++;
        if (res_o !== er || cout_o !== ec) begin
            errors++;
            $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b",
                     req, res_o, cout_o, er, ec);
        end
    endtask

    // Drive on a falling edge; one rising edge captures; read at the next falling edge.
    task automatic apply(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic cin);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; cin_i = cin;
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'd0: return "R2/R4 signed compare";
            2'd1: return "R3/R4 unsigned compare";
            2'd2: return "R5 carry";
            default: return "R7 byte match";
        endcase
    endfunction

    initial begin
        logic [31:0] er;
        logic        ec;
        logic [31:0] corner [4];
        corner[0] = 32'h0000_0000; corner[1] = 32'h7FFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;

        // R1: reset with busy inputs clears outputs.
        op_i = 2'd2; a_i = 32'h1; b_i = 32'hFFFF_FFFF; cin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 32'h0, 1'b0);
        rst = 1'b0;

        // Vector table.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cin);
            check(req_of(VECS[i].op), VECS[i].res, VECS[i].cout);
        end

        // R6: compare and match codes keep carry low even for overflowing operands.
        for (int op = 0; op < 4; op++) begin
            if (op == 2) continue;
            apply(2'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
            model(2'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, er, ec);
            check("R6 carry low off carry code", er, 1'b0);
        end

        // R8: first lane wins even when all lanes match.
        apply(2'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0);
        check("R8 first lane priority", 32'd1, 1'b0);
        // R9: every lane differs by one bit.
        apply(2'd3, 32'h0101_0101, 32'h0000_0000, 1'b0);
        check("R9 no lane equal", 32'd0, 1'b0);

        // R10: cin toggled gives identical compare and match results.
        for (int op = 0; op < 4; op++) begin
            if (op == 2) continue;
            apply(2'(op), 32'h8123_4567, 32'h0023_9999, 1'b0);
            model(2'(op), 32'h8123_4567, 32'h0023_9999, 1'b0, er, ec);
            check("R10 cin=0", er, ec);
            apply(2'(op), 32'h8123_4567, 32'h0023_9999, 1'b1);
            check("R10 cin=1", er, ec);
        end

        // Random and corner operands against the model.
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op;
            logic [31:0] a, b;
            logic        cin;
            op  = 2'($urandom);
            a   = $urandom;
            b   = $urandom;
            cin = 1'($urandom);
            if (($urandom % 3) == 0) a = corner[$urandom % 4];
            if (($urandom % 3) == 0) b = corner[$urandom % 4];
            if (($urandom % 8) == 0) b = {a[31:16], b[15:0]};
            model(op, a, b, cin, er, ec);
            apply(op, a, b, cin);
            check(req_of(op), er, ec);
        end

        // R1: one-cycle latency, outputs hold the captured value.
        apply(2'd0, 32'h0000_0001, 32'h0000_0004, 1'b0);
        op_i = 2'd3; a_i = 32'h0; b_i = 32'h1;
        #1;
        check("R1 output held until next edge", 32'h0000_0003, 1'b0);

        // R1: mid-run reset.
        @(negedge clk);
        rst = 1'b1; op_i = 2'd2; a_i = 32'h5; b_i = 32'hFFFF_FFFF; cin_i = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 32'h0, 1'b0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule